// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves bytes across a shared system bus on behalf of a host processor. Four channels each keep a 16-bit current address and a 16-bit current byte count, and each has its own mode: the transfer direction, and whether the address counts up or down. A peripheral asks for service on its request line, or software sets a request bit through the configuration port. The controller then raises a hold request to the processor. Once the processor acknowledges, the controller drives the address with an output enable, the pair of strobes for the direction, and the channel's acknowledge line, which selects the peripheral.

A command setting turns the block into a memory-to-memory copier. Channel 0 gives the source address and channel 1 the destination address. Each byte is read into an internal holding register and then written out. A second command bit keeps the source address fixed, so a single byte fills a whole region. A transfer ends when the count expires or when an end-of-process request arrives from outside. The controller drives its own end-of-process output during the final byte. A per-channel terminal-count flag records each completed transfer, and reading the status clears the flags.

Top module: `dma4_engine`

## Requirements
- R1: Reset clears the command, mask, software request and status registers. `status_o` reads 0. `hold_req`, `addr_oe`, all strobes and `dack` are low. Unmasked channels can be served without any further mask write.
- R2: A pending unmasked request raises `hold_req` the next cycle. No address enable, strobe or `dack` is driven until `hold_ack` has been sampled high. The first bus cycle follows the cycle in which `hold_ack` is seen.
- R3: Mode bit 0 chooses the direction. A value of 0 is a read from memory to I/O, which drives `mem_rd` and `io_wr` together. A value of 1 is a write from I/O to memory, which drives `io_rd` and `mem_wr`. The serviced channel's `dack` bit is high during each byte of an I/O transfer.
- R4: A byte completes on a clock edge where `ready` is high. Each completed byte moves the channel address by +1, or by -1 when mode bit 1 is set, wrapping at 16 bits. While `ready` is low, the address and strobes hold.
- R5: The count drops by one per byte. A programmed count N moves N+1 bytes. `eop_o` is high only during the last byte. After that byte, the channel's status flag sets, its software request clears and `hold_req` drops.
- R6: If `eop_i` is high on the edge where a byte completes, the transfer ends after that byte. The software request clears, the status flag stays clear and `hold_req` drops.
- R7: When several channels are pending, the lowest channel index is served first, and only one `dack` bit is ever high.
- R8: A set mask bit stops its channel from being served. Clearing the bit lets the pending request proceed.
- R9: In copy mode (command bit 0), a software request on channel 0 runs read/write pairs. The read uses `mem_rd` at channel 0's address and captures `data_i`. The write uses `mem_wr` at channel 1's address and drives that byte on `data_o`. Channel 1's count ends the copy and sets status bit 1. Command bit 1 holds channel 0's address fixed.
- R10: A status read pulse (`cfg_re`) clears all terminal-count flags on the next edge.
- R11: A hardware request keeps the bus for back-to-back bytes while the request line stays high. If the line is low on a byte's completing edge, the bus is released after that byte without a status flag. Software requests persist until the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: 0-3 address ch n, 4-7 count ch n, 8-11 mode ch n (bit0 direction, bit1 decrement), 12 command (bit0 copy, bit1 fixed source), 13 mask bits, 14 software request bits (set-only) |
| cfg_wdata | input | 16 | Register write data |
| cfg_re | input | 1 | Status read pulse, clears flags |
| status_o | output | 4 | Terminal-count flags, bit n for channel n |
| dreq | input | 4 | Hardware request lines |
| dack | output | 4 | Channel acknowledge / peripheral select |
| hold_req | output | 1 | Bus hold request to processor |
| hold_ack | input | 1 | Bus hold acknowledge from processor |
| ready | input | 1 | Bus cycle completes when high; low inserts waits |
| addr_o | output | 16 | Transfer address |
| addr_oe | output | 1 | Address output enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| data_i | input | 8 | Read data captured in copy mode |
| data_o | output | 8 | Held byte driven in copy write phase |
| data_oe | output | 1 | Data output enable in copy write phase |
| eop_i | input | 1 | External end-of-process (abort) |
| eop_o | output | 1 | Driven end-of-process, last byte |

## Verification
Count expiry and a wait state can fall in the same bus cycle. The bench holds `ready` low at random during the last byte and checks that `eop_o` and the address stay put until the completing edge, and that exactly N+1 bytes are logged. A status read clearing the flags and a new flag being set are both provoked around back-to-back transfers. The flag is judged by sampling `status_o` after each transfer and after each read pulse. Two requests raised in the same cycle are judged by the order of `dack` values in the byte log.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_RD,
        ST_WR
    } dma_st_e;
endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req_i,
    output logic           any_o,
    output logic [CW-1:0]  idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = CW'(i);
        end
    end

    // R7
    always_comb begin
        if (any_o) begin
            prio_pick_chk: assert (req_i[idx_o] && ((req_i & ((NCH'(1) << idx_o) - NCH'(1))) == '0));
        end
    end
endmodule

// File: rtl/dma4_step.sv
module dma4_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] cnt_i,
    input  logic          dec_i,
    input  logic          fix_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] cnt_o,
    output logic          last_o
);
    always_comb begin
        if (fix_i)      addr_o = addr_i;
        else if (dec_i) addr_o = addr_i - AW'(1);
        else            addr_o = addr_i + AW'(1);
        cnt_o  = cnt_i - AW'(1);
        last_o = (cnt_i == '0);
    end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int SW = $clog2(3 * NCH + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [SW-1:0]  cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic           cfg_re,
    output logic [NCH-1:0] status_o,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    output logic           hold_req,
    input  logic           hold_ack,
    input  logic           ready,
    output logic [AW-1:0]  addr_o,
    output logic           addr_oe,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr,
    input  logic [DW-1:0]  data_i,
    output logic [DW-1:0]  data_o,
    output logic           data_oe,
    input  logic           eop_i,
    output logic           eop_o
);
    import dma4_pkg::*;

    localparam int SEL_CMD  = 3 * NCH;
    localparam int SEL_MASK = 3 * NCH + 1;
    localparam int SEL_SREQ = 3 * NCH + 2;

    typedef struct packed {
        dma_st_e                 st;
        logic [CW-1:0]           ch;
        logic [NCH-1:0][AW-1:0]  addr;
        logic [NCH-1:0][AW-1:0]  cnt;
        logic [NCH-1:0][1:0]     mode;
        logic [1:0]              cmd;
        logic [NCH-1:0]          mask;
        logic [NCH-1:0]          sreq;
        logic [NCH-1:0]          tc;
        logic [DW-1:0]           hbuf;
    } eng_t;

    eng_t s_q, s_d;

    logic [NCH-1:0]          pend;
    logic                    pend_any;
    logic [CW-1:0]           pend_idx;
    logic [NCH-1:0][AW-1:0]  addr_nx;
    logic [NCH-1:0][AW-1:0]  cnt_nx;
    logic [NCH-1:0]          last;

    assign pend = (dreq | s_q.sreq) & ~s_q.mask;

    dma4_prio #(.NCH(NCH)) u_prio (
        .req_i (pend),
        .any_o (pend_any),
        .idx_o (pend_idx)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_step
        dma4_step #(.AW(AW)) u_step (
            .addr_i (s_q.addr[g]),
            .cnt_i  (s_q.cnt[g]),
            .dec_i  (s_q.mode[g][1]),
            .fix_i  ((g == 0) && s_q.cmd[0] && s_q.cmd[1]),
            .addr_o (addr_nx[g]),
            .cnt_o  (cnt_nx[g]),
            .last_o (last[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        hold_req = 1'b0;
        addr_oe  = 1'b0;
        addr_o   = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        dack     = '0;
        data_o   = '0;
        data_oe  = 1'b0;
        eop_o    = 1'b0;

        if (cfg_we) begin
            for (int i = 0; i < NCH; i++) begin
                if (cfg_sel == SW'(i))           s_d.addr[i] = cfg_wdata;
                if (cfg_sel == SW'(NCH + i))     s_d.cnt[i]  = cfg_wdata;
                if (cfg_sel == SW'(2 * NCH + i)) s_d.mode[i] = cfg_wdata[1:0];
            end
            if (cfg_sel == SW'(SEL_CMD))  s_d.cmd  = cfg_wdata[1:0];
            if (cfg_sel == SW'(SEL_MASK)) s_d.mask = cfg_wdata[NCH-1:0];
            if (cfg_sel == SW'(SEL_SREQ)) s_d.sreq = s_q.sreq | cfg_wdata[NCH-1:0];
        end
        if (cfg_re) s_d.tc = '0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (s_q.cmd[0]) begin
                    if (s_q.sreq[0] && !s_q.mask[0]) begin
                        s_d.st = ST_REQ;
                        s_d.ch = '0;
                    end
                end else if (pend_any) begin
                    s_d.st = ST_REQ;
                    s_d.ch = pend_idx;
                end
            end
            ST_REQ: begin
                hold_req = 1'b1;
                if (hold_ack) s_d.st = s_q.cmd[0] ? ST_RD : ST_XFER;
            end
            ST_XFER: begin
                hold_req       = 1'b1;
                addr_oe        = 1'b1;
                addr_o         = s_q.addr[s_q.ch];
                dack[s_q.ch]   = 1'b1;
                eop_o          = last[s_q.ch];
                if (s_q.mode[s_q.ch][0]) begin
                    io_rd  = 1'b1;
                    mem_wr = 1'b1;
                end else begin
                    mem_rd = 1'b1;
                    io_wr  = 1'b1;
                end
                if (ready) begin
                    s_d.addr[s_q.ch] = addr_nx[s_q.ch];
                    s_d.cnt[s_q.ch]  = cnt_nx[s_q.ch];
                    if (last[s_q.ch]) begin
                        s_d.tc[s_q.ch]   = 1'b1;
                        s_d.sreq[s_q.ch] = 1'b0;
                        s_d.st           = ST_IDLE;
                    end else if (eop_i) begin
                        s_d.sreq[s_q.ch] = 1'b0;
                        s_d.st           = ST_IDLE;
                    end else if (!pend[s_q.ch]) begin
                        s_d.st = ST_IDLE;
                    end
                end
            end
            ST_RD: begin
                hold_req = 1'b1;
                addr_oe  = 1'b1;
                addr_o   = s_q.addr[0];
                mem_rd   = 1'b1;
                if (ready) begin
                    s_d.hbuf = data_i;
                    s_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                hold_req = 1'b1;
                addr_oe  = 1'b1;
                addr_o   = s_q.addr[1];
                mem_wr   = 1'b1;
                data_o   = s_q.hbuf;
                data_oe  = 1'b1;
                eop_o    = last[1];
                if (ready) begin
                    s_d.addr[0] = addr_nx[0];
                    s_d.addr[1] = addr_nx[1];
                    s_d.cnt[0]  = cnt_nx[0];
                    s_d.cnt[1]  = cnt_nx[1];
                    if (last[1]) begin
                        s_d.tc[1]   = 1'b1;
                        s_d.sreq[0] = 1'b0;
                        s_d.st      = ST_IDLE;
                    end else if (eop_i) begin
                        s_d.sreq[0] = 1'b0;
                        s_d.st      = ST_IDLE;
                    end else begin
                        s_d.st = ST_RD;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign status_o = s_q.tc;

    // R2
    strobe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe || mem_rd || mem_wr || io_rd || io_wr || (dack != '0)) |-> hold_req);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(io_rd && io_wr));

    // R4
    wait_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe && !ready) |=> (addr_oe && $stable(addr_o) && $stable(dack)));

    // R5
    eop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_o && ready) |=> !hold_req);

    // R7
    dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));
endmodule

// File: tb/dma4_engine_bench.sv
module dma4_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        cfg_re = 1'b0;
    logic [3:0]  status_o;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic        ready = 1'b1;
    logic [15:0] addr_o;
    logic        addr_oe, mem_rd, mem_wr, io_rd, io_wr;
    logic [7:0]  data_i;
    logic [7:0]  data_o;
    logic        data_oe;
    logic        eop_i = 1'b0;
    logic        eop_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit ack_auto = 1'b1;
    bit rdy_rand = 1'b0;

    logic [7:0]  mem [256];
    logic [15:0] lg_addr [64];
    logic [3:0]  lg_kind [64];
    logic [3:0]  lg_dack [64];
    logic        lg_eop  [64];
    logic [7:0]  lg_data [64];
    int          n_log = 0;

    always #4 clk = ~clk;

    dma4_engine u_dma4_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_re(cfg_re), .status_o(status_o),
        .dreq(dreq), .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack),
        .ready(ready), .addr_o(addr_o), .addr_oe(addr_oe), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .data_i(data_i),
        .data_o(data_o), .data_oe(data_oe), .eop_i(eop_i), .eop_o(eop_o)
    );

    assign data_i = mem[addr_o[7:0]];

    always @(negedge clk) begin
        hold_ack <= ack_auto ? hold_req : 1'b0;
        ready    <= rdy_rand ? (($urandom % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        #2;
        if (addr_oe && ready && n_log < 64) begin
            lg_addr[n_log] = addr_o;
            lg_kind[n_log] = {mem_rd, mem_wr, io_rd, io_wr};
            lg_dack[n_log] = dack;
            lg_eop[n_log]  = eop_o;
            lg_data[n_log] = data_o;
            n_log++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_status();
        @(negedge clk);
        cfg_re = 1'b1;
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] c, input logic [1:0] m);
        wr(4'(ch), a);
        wr(4'(4 + ch), c);
        wr(4'(8 + ch), {14'd0, m});
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!hold_req && t < 50) begin @(negedge clk); t++; end
        t = 0;
        while (hold_req && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) chk(1'b0, {tag, " watchdog"}, 32'(t), 0);
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] a0, input int k, input logic [1:0] m);
        return m[1] ? a0 - 16'(k) : a0 + 16'(k);
    endfunction

    function automatic logic [3:0] exp_kind(input logic [1:0] m);
        return m[0] ? 4'b0110 : 4'b1001;
    endfunction

    task automatic check_block(input int base, input int ch, input logic [15:0] a0,
                               input int cnt, input logic [1:0] m, input string tag);
        for (int k = 0; k <= cnt; k++) begin
            int j = base + k;
            chk(lg_addr[j] == exp_addr(a0, k, m) && lg_kind[j] == exp_kind(m) &&
                lg_dack[j] == 4'(1 << ch) && lg_eop[j] == (k == cnt),
                tag, {lg_addr[j], 3'd0, lg_eop[j], lg_kind[j], lg_dack[j], 4'd0},
                {exp_addr(a0, k, m), 3'd0, 1'(k == cnt), exp_kind(m), 4'(1 << ch), 4'd0});
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(status_o == 0 && !hold_req && !addr_oe && dack == 0 &&
            !mem_rd && !mem_wr && !io_rd && !io_wr, "R1 reset outputs",
            {status_o, hold_req, addr_oe, dack}, 0);

        // R2: hold before bus, memory-to-I/O read, increment
        ack_auto = 1'b0;
        prog(2, 16'h1000, 16'd2, 2'b00);
        wr(4'd14, 16'h0004);
        repeat (5) @(negedge clk);
        chk(hold_req && !addr_oe && dack == 0 && !mem_rd && !io_wr, "R2 hold without ack",
            {hold_req, addr_oe, dack}, {1'b1, 1'b0, 4'd0});
        n_log = 0;
        ack_auto = 1'b1;
        wait_done("R2");
        chk(n_log == 3, "R5 byte count N+1", n_log, 3);
        check_block(0, 2, 16'h1000, 2, 2'b00, "R3 R4 R5 read block");
        chk(status_o == 4'b0100, "R5 tc flag", status_o, 4'b0100);
        rd_status();
        chk(status_o == 0, "R10 read clears", status_o, 0);

        // R4: write direction, decrement, wait states, address wrap
        rdy_rand = 1'b1;
        prog(1, 16'h0001, 16'd3, 2'b11);
        n_log = 0;
        wr(4'd14, 16'h0002);
        wait_done("R4");
        chk(n_log == 4, "R4 count with waits", n_log, 4);
        check_block(0, 1, 16'h0001, 3, 2'b11, "R3 R4 write dec wrap");
        rdy_rand = 1'b0;
        rd_status();

        // R7: priority with two simultaneous requests
        prog(1, 16'h0200, 16'd1, 2'b00);
        prog(3, 16'h0300, 16'd1, 2'b01);
        n_log = 0;
        wr(4'd14, 16'h000A);
        wait_done("R7a");
        wait_done("R7b");
        chk(n_log == 4, "R7 total bytes", n_log, 4);
        check_block(0, 1, 16'h0200, 1, 2'b00, "R7 low index first");
        check_block(2, 3, 16'h0300, 1, 2'b01, "R7 then ch3");
        chk(status_o == 4'b1010, "R7 both flags", status_o, 4'b1010);
        rd_status();

        // R8: mask blocks channel
        wr(4'd13, 16'h0001);
        prog(0, 16'h0400, 16'd0, 2'b00);
        n_log = 0;
        wr(4'd14, 16'h0001);
        repeat (20) @(negedge clk);
        chk(!hold_req && n_log == 0, "R8 masked ignored", {hold_req, 8'(n_log)}, 0);
        wr(4'd13, 16'h0000);
        wait_done("R8");
        chk(n_log == 1 && status_o == 4'b0001, "R8 unmask serves", {8'(n_log), status_o}, {8'd1, 4'b0001});
        rd_status();

        // R6: external end-of-process aborts after first byte
        prog(0, 16'h0500, 16'd9, 2'b00);
        eop_i = 1'b1;
        n_log = 0;
        wr(4'd14, 16'h0001);
        wait_done("R6");
        eop_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_log == 1 && status_o == 0 && !hold_req, "R6 abort",
            {8'(n_log), status_o, hold_req}, {8'd1, 4'd0, 1'b0});

        // R11: demand request, released when line drops
        prog(3, 16'h0300, 16'h00FF, 2'b00);
        n_log = 0;
        dreq = 4'b1000;
        begin
            int nb;
            int t = 0;
            while (n_log < 4 && t < 100) begin @(negedge clk); t++; end
            nb = n_log;
            dreq = 4'b0000;
            repeat (6) @(negedge clk);
            chk(n_log == nb + 1 && !hold_req && status_o == 0, "R11 demand release",
                {8'(n_log), hold_req, status_o}, {8'(nb + 1), 1'b0, 4'd0});
            chk(lg_addr[nb] == 16'h0300 + 16'(nb), "R11 contiguous addr", lg_addr[nb], 16'h0300 + 16'(nb));
        end

        // R9: memory-to-memory copy
        wr(4'd12, 16'h0001);
        prog(0, 16'h0040, 16'd3, 2'b00);
        prog(1, 16'h0080, 16'd3, 2'b00);
        n_log = 0;
        wr(4'd14, 16'h0001);
        wait_done("R9");
        chk(n_log == 8 && status_o == 4'b0010, "R9 copy length and flag",
            {8'(n_log), status_o}, {8'd8, 4'b0010});
        for (int k = 0; k < 4; k++) begin
            chk(lg_kind[2*k] == 4'b1000 && lg_addr[2*k] == 16'h0040 + 16'(k),
                "R9 read phase", {lg_kind[2*k], lg_addr[2*k]}, {4'b1000, 16'h0040 + 16'(k)});
            chk(lg_kind[2*k+1] == 4'b0100 && lg_addr[2*k+1] == 16'h0080 + 16'(k) &&
                lg_data[2*k+1] == mem[8'h40 + 8'(k)] && lg_eop[2*k+1] == (k == 3),
                "R9 write phase", {lg_data[2*k+1], lg_addr[2*k+1]}, {mem[8'h40 + 8'(k)], 16'h0080 + 16'(k)});
        end
        rd_status();

        // R9: fixed-source fill
        wr(4'd12, 16'h0003);
        prog(0, 16'h0050, 16'd2, 2'b00);
        prog(1, 16'h0090, 16'd2, 2'b00);
        n_log = 0;
        wr(4'd14, 16'h0001);
        wait_done("R9 fill");
        chk(n_log == 6, "R9 fill length", n_log, 6);
        for (int k = 0; k < 3; k++) begin
            chk(lg_addr[2*k] == 16'h0050 && lg_data[2*k+1] == mem[8'h50] &&
                lg_addr[2*k+1] == 16'h0090 + 16'(k), "R9 fill fixed source",
                {lg_addr[2*k], lg_data[2*k+1]}, {16'h0050, mem[8'h50]});
        end
        wr(4'd12, 16'h0000);
        rd_status();

        // R3 R4 R5: random blocks with random waits
        rdy_rand = 1'b1;
        for (int it = 0; it < 8; it++) begin
            int ch = int'($urandom % 4);
            int cnt = int'($urandom % 6);
            logic [15:0] a0 = 16'($urandom);
            logic [1:0] m = 2'($urandom % 4);
            prog(ch, a0, 16'(cnt), m);
            n_log = 0;
            wr(4'd14, 16'(1 << ch));
            wait_done("rand");
            chk(n_log == cnt + 1 && status_o == 4'(1 << ch), "R5 random length/flag",
                {8'(n_log), status_o}, {8'(cnt + 1), 4'(1 << ch)});
            check_block(0, ch, a0, cnt, m, "R4 random block");
            rd_status();
            chk(status_o == 0, "R10 random clear", status_o, 0);
        end
        rdy_rand = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule